// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Centred Sample Trigger

This block drives one half-bridge phase from an up/down counter. Each period is a triangle: the counter rises from the valley (zero) to the peak (the programmed half-period count) and falls back again. The output is centred on the valley. A new duty value is taken at every turn-around, so the control loop can act twice per PWM period. The active period and lead values are also held and refreshed only at turn-arounds, so a write made while a half-cycle is in progress cannot cause a glitch.

Around each turn-around the block places a measurement window of programmable half-length. A filter-start pulse opens the window that many clocks before the turn-around. A centre pulse marks the turn-around itself. An update-request pulse closes the window the same number of clocks after it. The sample is therefore taken at the quiet switching instant, and the control law is told when fresh data is ready. All four outputs are cleared while the enable is low.

Top module: `center_pwm_trig`

## Requirements
- R1: While `en` is low, `cnt_pwm`, `filt_start`, `win_center` and `upd_req` are low, and the counter is held at the valley. One clock after `en` falls, all four outputs are low.
- R2: With period value P (P at least 2), one PWM period lasts 2P clocks. `win_center` pulses once at every turn-around, so consecutive pulses are P clocks apart. The first pulse after `en` rises appears on the first clock that `en` is sampled high, and it marks a valley.
- R3: Over one PWM period that starts at a valley, `cnt_pwm` is high for 2·min(D,P) clocks, centred on the valley. D = 0 keeps the output low and D ≥ P keeps it high.
- R4: A change to `duty` takes effect only from the next turn-around, valley or peak. The half-cycle already running keeps the earlier value.
- R5: A change to `period` takes effect only from the next valley. The half-cycles before that valley keep the earlier length.
- R6: For a lead L with 0 < L < P, `filt_start` pulses exactly L clocks before every `win_center` pulse except the first one after enabling.
- R7: For 0 < L < P, `upd_req` pulses exactly L clocks after every `win_center` pulse.
- R8: For L = 0 or L ≥ P, both `filt_start` and `upd_req` coincide with `win_center`. When L ≥ P the trigger therefore lands on the opposite turn-around.
- R9: Every strobe lasts exactly one clock. `win_center` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low clears everything |
| period | input | CW | Half-period count P (counter peak value) |
| duty | input | CW | On-time count D per half period |
| lead | input | CW | Measurement window half-length L in clocks |
| cnt_pwm | output | 1 | PWM output |
| filt_start | output | 1 | Window-open pulse |
| win_center | output | 1 | Turn-around (window centre) pulse |
| upd_req | output | 1 | Window-close / control-update pulse |

## Verification
The in-module properties assume that `period` is at least 2 whenever it can be loaded. With a smaller value a half-cycle would shrink to one clock, and the single-cycle pulse property and the counter-range property would no longer mean anything. The bench only ever programs periods of 6 and 10. It changes `duty` and `period` only on falling clock edges, at known counter phases, so each property sees a legal sequence of shadow loads. The lead values it uses cover the clamped cases (0, equal to P, above P) as well as the in-range case.

// File: rtl/center_pwm_trig.sv
module center_pwm_trig #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] lead,
  output logic          cnt_pwm,
  output logic          filt_start,
  output logic          win_center,
  output logic          upd_req
);

  logic [CW-1:0] cnt, act_per, act_duty, act_lead;
  logic          up;

  logic peak, valley, turn;
  assign peak   = up && (cnt >= act_per);
  assign valley = !up && (cnt == '0);
  assign turn   = peak || valley;

  logic [CW-1:0] per_eff, duty_eff, lead_eff, le;
  assign per_eff  = valley ? period : act_per;
  assign duty_eff = turn ? duty : act_duty;
  assign lead_eff = turn ? lead : act_lead;
  assign le       = (lead_eff > per_eff) ? per_eff : lead_eff;

  logic edge_case;
  assign edge_case = (le == '0) || (le == per_eff);

  logic fs_n, upd_n, pwm_n;
  assign fs_n  = edge_case ? turn : (up ? (cnt == per_eff - le) : (cnt == le));
  assign upd_n = edge_case ? turn : (up ? (cnt == le) : (cnt == per_eff - le));
  assign pwm_n = {1'b0, cnt} < ({1'b0, duty_eff} + {{CW{1'b0}}, up});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      up         <= 1'b0;
      act_per    <= '0;
      act_duty   <= '0;
      act_lead   <= '0;
      cnt_pwm    <= 1'b0;
      filt_start <= 1'b0;
      win_center <= 1'b0;
      upd_req    <= 1'b0;
    end else if (!en) begin
      cnt        <= '0;
      up         <= 1'b0;
      act_per    <= period;
      act_duty   <= duty;
      act_lead   <= lead;
      cnt_pwm    <= 1'b0;
      filt_start <= 1'b0;
      win_center <= 1'b0;
      upd_req    <= 1'b0;
    end else begin
      cnt_pwm    <= pwm_n;
      filt_start <= fs_n;
      win_center <= turn;
      upd_req    <= upd_n;
      if (valley) act_per <= period;
      if (turn) begin
        act_duty <= duty;
        act_lead <= lead;
      end
      if (peak) begin
        cnt <= cnt - 1'b1;
        up  <= 1'b0;
      end else if (valley) begin
        cnt <= {{(CW-1){1'b0}}, 1'b1};
        up  <= 1'b1;
      end else begin
        cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
      end
    end
  end

  // R1: disabling clears every output on the next clock
  a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !cnt_pwm && !filt_start && !win_center && !upd_req);

  // R2: falling count steps down by exactly one
  a_r2_fall_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R5: counter never exceeds the active peak
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (act_per >= 2) |-> (cnt <= act_per));

  // R3: zero duty yields a low output
  a_r3_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (en && duty_eff == '0) |=> !cnt_pwm);

  // R9: centre strobe lasts one clock
  a_r9_center_single: assert property (@(posedge clk) disable iff (!rst_n)
    (win_center && act_per >= 2) |=> !win_center);

  // R8: clamped lead puts both strobes on the turn-around
  a_r8_clamp_coincide: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_per >= 2 && lead_eff >= per_eff) |=> (filt_start == win_center) && (upd_req == win_center));

endmodule

// File: tb/test_center_pwm_trig.sv
module test_center_pwm_trig;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [CW-1:0] period = '0, duty = '0, lead = '0;
  logic pwm, fs, wc, upd;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  center_pwm_trig #(.CW(CW)) i_center_pwm_trig (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .duty(duty), .lead(lead),
    .cnt_pwm(pwm), .filt_start(fs), .win_center(wc), .upd_req(upd));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(input int p, input int d, input int l);
    @(negedge clk);
    en = 1'b0; period = p[CW-1:0]; duty = d[CW-1:0]; lead = l[CW-1:0];
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({pwm, fs, wc, upd} == 4'b0, "R1 reset/idle", {pwm, fs, wc, upd}, 0);
  endtask

  task automatic run_mode(input int p, input int d, input int l);
    int last_wc = -1, last_fs = -1000, highs = 0;
    int err_sp = 0, err_fs = 0, err_up = 0, err_co = 0, err_dbl = 0;
    bit prev_wc = 1'b0;
    int mn;
    start(p, d, l);
    for (int k = 0; k < 4 * p; k++) begin
      @(negedge clk);
      if (k == 0) check(wc === 1'b1, "R2 first centre", wc, 1);
      if (k < 2 * p && pwm) highs++;
      if (wc && prev_wc) err_dbl++;
      prev_wc = wc;
      if (l == 0 || l >= p) begin
        if (fs !== wc || upd !== wc) err_co++;
      end else begin
        if (fs) last_fs = k;
        if (wc && k > 0 && last_fs != k - l) err_fs++;
        if (upd && (k - last_wc) != l) err_up++;
      end
      if (wc) begin
        if (k > 0 && (k - last_wc) != p) err_sp++;
        last_wc = k;
      end
    end
    mn = (d < p) ? d : p;
    check(highs == 2 * mn, "R3 high count", highs, 2 * mn);
    check(err_sp == 0, "R2 centre spacing", err_sp, 0);
    check(err_dbl == 0, "R9 single pulse", err_dbl, 0);
    if (l == 0 || l >= p) check(err_co == 0, "R8 clamped strobes", err_co, 0);
    else begin
      check(err_fs == 0, "R6 filter lead", err_fs, 0);
      check(err_up == 0, "R7 update lag", err_up, 0);
    end
  endtask

  task automatic t_duty_shadow();
    int h1 = 0, h2 = 0;
    start(10, 3, 2);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k == 10) begin
        check(wc === 1'b1, "R4 peak centre", wc, 1);
        duty = 16'd7;
      end
      if (k >= 11 && k <= 19 && pwm) h1++;
      if (k >= 20 && pwm) h2++;
    end
    check(h1 == 2, "R4 old duty kept", h1, 2);
    check(h2 == 8, "R4 new duty at valley", h2, 8);
  endtask

  task automatic t_period_shadow();
    int pos[5];
    int n = 0;
    start(10, 4, 2);
    for (int k = 0; k < 34; k++) begin
      @(negedge clk);
      if (k == 0) period = 16'd6;
      if (wc && n < 5) begin pos[n] = k; n++; end
    end
    check(n == 5, "R5 centre count", n, 5);
    check(pos[1] == 10 && pos[2] == 20, "R5 old period kept", pos[2], 20);
    check(pos[3] == 26 && pos[4] == 32, "R5 new period", pos[4], 32);
  endtask

  task automatic t_disable();
    start(10, 10, 3);
    repeat (5) @(negedge clk);
    check(pwm === 1'b1, "R3 full duty high", pwm, 1);
    en = 1'b0;
    @(negedge clk);
    check({pwm, fs, wc, upd} == 4'b0, "R1 disable clears", {pwm, fs, wc, upd}, 0);
    en = 1'b1;
    @(negedge clk);
    check(wc === 1'b1, "R2 restart at valley", wc, 1);
  endtask

  initial begin
    t_reset();
    run_mode(10, 4, 3);
    run_mode(10, 0, 3);
    run_mode(10, 10, 4);
    run_mode(10, 13, 2);
    run_mode(10, 6, 12);
    run_mode(10, 5, 10);
    run_mode(6, 2, 0);
    t_duty_shadow();
    t_period_shadow();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule